// File: doc/BRIEF.md
# Fixed-Priority Four-Way Bus Arbiter

This block decides which of four requesting devices owns a shared bus during each clock period. It is a Moore machine with five states: an idle state, in which nobody owns the bus, and one ownership state for each device. The grant outputs are decoded from the registered state alone, so they are free of combinational paths from the request lines. A request sampled on a rising edge shows up as a grant in the clock period that follows that edge.

Device priority is fixed, and a lower index wins. A static policy input chooses between two behaviours. With the input low, the arbiter preempts: on every edge it hands the bus to the lowest-numbered active requester, even if another device holds it. With the input high, the arbiter holds: the current owner keeps the bus for as long as its own request stays asserted. When that owner lets go, the bus passes on the same edge to the best pending requester, or the arbiter goes idle. The policy input may only change while reset is asserted.

Top module: `arb_fixed_prio`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset with no requests present, all four grant outputs are 0.
- R2: At most one grant bit is 1 in every clock period. Grant bit k being 1 means device k owns the bus.
- R3: From the idle state (all grants 0), when at least one request is sampled, the next cycle grants only the lowest-indexed active requester, in either policy.
- R4: In preempt mode (hold_mode_i = 0), a sampled request on line 0 gives grant 0 in the next cycle, whatever the other request lines and the current owner are.
- R5: In preempt mode, when a lower-indexed request is sampled while a higher-indexed device owns the bus, ownership moves to the lowest-indexed active requester in the next cycle.
- R6: In hold mode (hold_mode_i = 1), an owner whose request is still 1 keeps its grant in the next cycle, even while lower-indexed devices request.
- R7: In hold mode, when the owner's request is sampled at 0 and other requests are pending, the next cycle grants the lowest-indexed pending requester, with no idle cycle in between.
- R8: When all request lines are sampled at 0, every grant is 0 in the next cycle, in either policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to idle |
| hold_mode_i | input | 1 | Policy: 0 = preempt, 1 = owner holds until release; static outside reset |
| req_i | input | 4 | Request line per device; bit 0 has highest priority |
| gnt_o | output | 4 | One-hot-or-zero grant per device, decoded from state |

## Verification
The properties assume that the policy input changes only while reset is asserted. One assertion checks this. The bench therefore sets the policy before it releases reset and never changes it during a run. Apart from that, the request lines may take any value on any cycle. The bench applies every sequence of three request patterns under each policy. This drives the machine into every owner state with every combination of pending requests, including cases where the owner releases and higher-priority devices are already waiting.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int ARB_N     = 4;
    localparam int ARB_IDX_W = (ARB_N > 1) ? $clog2(ARB_N) : 1;

    typedef struct packed {
        logic                 busy;
        logic [ARB_IDX_W-1:0] owner;
    } arb_state_t;

    localparam arb_state_t ARB_IDLE = '{busy: 1'b0, owner: '0};
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest active index is written last and wins.
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/arb_next_state.sv
module arb_next_state
    import arb_pkg::*;
(
    input  arb_state_t       state_q,
    input  logic [ARB_N-1:0] req_i,
    input  logic             hold_mode_i,
    output arb_state_t       state_d
);
    logic                 pick_any;
    logic [ARB_IDX_W-1:0] pick_idx;
    logic                 owner_still_req;

    arb_prio_pick #(
        .N     (ARB_N),
        .IDX_W (ARB_IDX_W)
    ) u_pick (
        .req_i (req_i),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    always_comb begin
        owner_still_req = state_q.busy && req_i[state_q.owner];
        if (hold_mode_i && owner_still_req) begin
            state_d = state_q;
        end else if (pick_any) begin
            state_d = '{busy: 1'b1, owner: pick_idx};
        end else begin
            state_d = ARB_IDLE;
        end
    end
endmodule

// File: rtl/arb_grant_decode.sv
module arb_grant_decode
    import arb_pkg::*;
(
    input  arb_state_t       state_q,
    output logic [ARB_N-1:0] gnt_o
);
    for (genvar g = 0; g < ARB_N; g++) begin : g_gnt
        assign gnt_o[g] = state_q.busy && (state_q.owner == ARB_IDX_W'(g));
    end
endmodule

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio
    import arb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_mode_i,
    input  logic [ARB_N-1:0] req_i,
    output logic [ARB_N-1:0] gnt_o
);
    arb_state_t state_d;
    arb_state_t state_q;

    arb_next_state u_next (
        .state_q     (state_q),
        .req_i       (req_i),
        .hold_mode_i (hold_mode_i),
        .state_d     (state_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    arb_grant_decode u_dec (
        .state_q (state_q),
        .gnt_o   (gnt_o)
    );

    // Input assumption: the policy changes only under reset.
    p_mode_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(hold_mode_i));

    p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    p_idle_pick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o == '0 && req_i != '0) |=>
        (gnt_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    p_zero_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_mode_i && req_i[0]) |=> gnt_o[0]);

    p_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_mode_i && req_i != '0) |=>
        (gnt_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_mode_i && (gnt_o & req_i) != '0) |=> (gnt_o == $past(gnt_o)));

    p_handoff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_mode_i && gnt_o != '0 && (gnt_o & req_i) == '0 && req_i != '0) |=>
        (gnt_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == '0) |=> (gnt_o == '0));
endmodule

// File: tb/arb_fixed_prio_bench.sv
module arb_fixed_prio_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hold_mode = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic m_busy;
    int   m_owner;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arb_fixed_prio u_arb_fixed_prio (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hold_mode_i (hold_mode),
        .req_i       (req),
        .gnt_o       (gnt)
    );

    task automatic check(input string tag, input logic [N-1:0] exp);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s: gnt=%b expected=%b (mode=%0b req=%b)", tag, gnt, exp, hold_mode, req);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Caller is at a falling edge. Drive r, advance the model, check at the next falling edge.
    task automatic step(input logic [N-1:0] r);
        string        tag;
        logic         was_busy;
        int           was_owner;
        int           low;
        logic [N-1:0] exp;
        int           ones;
        was_busy  = m_busy;
        was_owner = m_owner;
        req = r;
        low = -1;
        for (int i = N - 1; i >= 0; i--) if (r[i]) low = i;
        if (hold_mode && m_busy && r[m_owner]) begin
            tag = "R6";
        end else if (low >= 0) begin
            m_busy  = 1'b1;
            m_owner = low;
            if (!was_busy)                 tag = "R3";
            else if (!hold_mode && r[0])   tag = "R4";
            else if (!hold_mode)           tag = "R5";
            else                           tag = "R7";
        end else begin
            m_busy = 1'b0;
            tag = "R8";
        end
        exp = m_busy ? N'(1 << m_owner) : '0;
        @(negedge clk);
        check(tag, exp);
        ones = $countones(gnt);
        checks++;
        if (ones > 1) begin
            errors++;
            $display("FAIL R2: gnt=%b has %0d bits set, expected at most 1", gnt, ones);
        end
    endtask

    task automatic run_mode(input logic mode);
        rst_n = 1'b0;
        req = '0;
        hold_mode = mode;
        m_busy = 1'b0;
        m_owner = 0;
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 16; c++) begin
                    step(N'(a));
                    step(N'(b));
                    step(N'(c));
                end
            end
        end
        // Directed cases: owner 3 under pressure from device 0.
        step(4'b1000);
        step(4'b1001);
        step(4'b0001);
        step(4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        finish_run();
    end
endmodule